// File: doc/BRIEF.md
# First-Eight Hit Selector Encoder

This block condenses a hit map of 128 strips, each holding 32 pixels, into at most eight compact words per bunch period. A start strobe marks a new period. On that edge the block takes in the latched hit bits. Each strip is reduced to a code that holds the column of its lowest hit pixel and a flag for a second hit. Strips that have no hit are skipped. The first eight hit strips, in ascending strip order, are then placed onto eight fixed output slots. A saturating running count of the hit strips that come before each strip picks its slot.

Selection runs in two registered stages. The first stage compacts each group of 32 strips into its own first eight hits. The second stage merges the four groups into the final eight slots. On the start edge the output slots are cleared, so nothing from the previous period can remain. The new results appear one clock later, which is well inside a 25 ns period at 40 MHz. A separate flag reports when more than eight strips were hit.

Top module: `hit_sel_top`

## Requirements
- R1: Pixel c of strip s is input bit `hit_map[s*32+c]`. The code of a hit strip carries the lowest set column index of that strip. Its multi-hit flag is 1 exactly when two or more pixels of the strip are set.
- R2: Slot i is `slot_word[i*13 +: 13]`. Bits 12..6 hold the strip index, bits 5..1 the column and bit 0 the multi-hit flag.
- R3: Hit strips are assigned in ascending strip index. The k-th hit strip (k counted from 0) goes to slot k, so the strip indices in valid slots strictly increase with the slot number.
- R4: Strips with no set pixel take no slot. A slot that is not filled has `slot_valid[i]`=0 and a word of all zeros, and the valid slots always form a contiguous run starting at slot 0.
- R5: At most eight slots are ever filled. `overflow` is 1 exactly when more than eight strips of the map were hit, whether those strips sit in one group or are spread over several groups. When `overflow` is 1, all eight slots are valid.
- R6: A map sampled on the rising edge where `start`=1 shows its results on `slot_word`, `slot_valid` and `overflow` after the next rising edge.
- R7: After the rising edge that samples `start`, and before the results arrive, every slot reads zero with valid low and `overflow` is 0.
- R8: Synchronous active-high `rst` clears all slots, all valid bits and `overflow`.
- R9: Without a new `start`, the outputs hold their last results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Period strobe; samples `hit_map` on this edge |
| hit_map | input | 4096 | Latched pixel hits, 32 bits per strip |
| slot_word | output | 104 | Eight 13-bit hit words, slot 0 in the low bits |
| slot_valid | output | 8 | Per-slot valid bit |
| overflow | output | 1 | More than eight strips were hit |

## Verification
The maps used are:
- An empty map, which shows that idle strips fill no slots.
- A single pixel at the last strip and column, which exercises the widest address fields.
- Strips with two hits, which separate the lowest-column rule from the multi-hit flag.
- Exactly eight hit strips placed at the end of the map, which is the slowest case for the skip logic.
- Nine hit strips, and a map with every pixel set, which cover the saturation boundary.
- Three hits in each of the four groups, which can only overflow in the merge stage and so tells a per-group fault from a merge fault.

Random maps with a fixed seed and from 0 to 14 hit strips add mixed orderings. Each map is checked for the cleared slots that come before its results, and for the outputs holding steady afterwards.

// File: rtl/hitsel_pkg.sv
package hitsel_pkg;
    localparam int NSTRIP = 128;
    localparam int NPIX   = 32;
    localparam int NSLOT  = 8;
    localparam int GSIZE  = 32;
    localparam int NGROUP = NSTRIP / GSIZE;
    localparam int SAW    = $clog2(NSTRIP);
    localparam int CAW    = $clog2(NPIX);
    localparam int SIW    = $clog2(NSLOT);
    localparam int CNTW   = $clog2(NSLOT + 1);
    localparam int WORDW  = SAW + CAW + 1;

    typedef struct packed {
        logic [SAW-1:0] strip;
        logic [CAW-1:0] col;
        logic           multi;
    } hit_word_t;

    typedef struct packed {
        logic           hit;
        logic [CAW-1:0] col;
        logic           multi;
    } strip_code_t;

    typedef struct packed {
        hit_word_t [NSLOT-1:0] word;
        logic [CNTW-1:0]       cnt;
        logic                  over;
    } group_res_t;

    function automatic logic [CNTW-1:0] sat_inc(input logic [CNTW-1:0] c);
        return (c == CNTW'(NSLOT)) ? c : c + 1'b1;
    endfunction
endpackage

// File: rtl/strip_encoder.sv
module strip_encoder
    import hitsel_pkg::*;
(
    input  logic [NPIX-1:0] pix,
    output strip_code_t     code
);
    always_comb begin
        code = '0;
        for (int c = NPIX - 1; c >= 0; c--) begin
            if (pix[c]) code.col = CAW'(c);
        end
        code.hit   = |pix;
        code.multi = (pix & (pix - NPIX'(1))) != '0;
    end
endmodule

// File: rtl/group_compactor.sv
module group_compactor
    import hitsel_pkg::*;
#(
    parameter int GBASE = 0
) (
    input  logic [GSIZE*NPIX-1:0] pix,
    output group_res_t            res
);
    strip_code_t codes [GSIZE];

    for (genvar s = 0; s < GSIZE; s++) begin : g_enc
        strip_encoder u_enc (
            .pix  (pix[s*NPIX +: NPIX]),
            .code (codes[s])
        );
    end

    always_comb begin
        logic [CNTW-1:0] cnt;
        cnt = '0;
        res = '0;
        for (int i = 0; i < GSIZE; i++) begin
            if (codes[i].hit) begin
                if (cnt == CNTW'(NSLOT)) begin
                    res.over = 1'b1;
                end else begin
                    res.word[cnt[SIW-1:0]].strip = SAW'(GBASE + i);
                    res.word[cnt[SIW-1:0]].col   = codes[i].col;
                    res.word[cnt[SIW-1:0]].multi = codes[i].multi;
                end
                cnt = sat_inc(cnt);
            end
        end
        res.cnt = cnt;
    end
endmodule

// File: rtl/merge_stage.sv
module merge_stage
    import hitsel_pkg::*;
(
    input  group_res_t            grp [NGROUP],
    output hit_word_t [NSLOT-1:0] word,
    output logic [NSLOT-1:0]      valid,
    output logic                  over
);
    always_comb begin
        logic [CNTW-1:0] total;
        total = '0;
        word  = '0;
        valid = '0;
        over  = 1'b0;
        for (int g = 0; g < NGROUP; g++) begin
            over = over | grp[g].over;
            for (int j = 0; j < NSLOT; j++) begin
                if (CNTW'(j) < grp[g].cnt) begin
                    if (total == CNTW'(NSLOT)) begin
                        over = 1'b1;
                    end else begin
                        word[total[SIW-1:0]]  = grp[g].word[j];
                        valid[total[SIW-1:0]] = 1'b1;
                    end
                    total = sat_inc(total);
                end
            end
        end
    end
endmodule

// File: rtl/hit_sel_top.sv
module hit_sel_top
    import hitsel_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NSTRIP*NPIX-1:0]  hit_map,
    output logic [NSLOT*WORDW-1:0]  slot_word,
    output logic [NSLOT-1:0]        slot_valid,
    output logic                    overflow
);
    group_res_t grp_c  [NGROUP];
    group_res_t s1_grp [NGROUP];
    logic       s1_valid;

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        group_compactor #(.GBASE(g * GSIZE)) u_grp (
            .pix (hit_map[g*GSIZE*NPIX +: GSIZE*NPIX]),
            .res (grp_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_grp   <= '{default: '0};
        end else begin
            s1_valid <= start;
            if (start) s1_grp <= grp_c;
        end
    end

    hit_word_t [NSLOT-1:0] m_word;
    logic [NSLOT-1:0]      m_valid;
    logic                  m_over;

    merge_stage u_merge (
        .grp   (s1_grp),
        .word  (m_word),
        .valid (m_valid),
        .over  (m_over)
    );

    hit_word_t [NSLOT-1:0] out_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word   <= '0;
            slot_valid <= '0;
            overflow   <= 1'b0;
        end else if (s1_valid) begin
            out_word   <= m_word;
            slot_valid <= m_valid;
            overflow   <= m_over;
        end else if (start) begin
            out_word   <= '0;
            slot_valid <= '0;
            overflow   <= 1'b0;
        end
    end

    assign slot_word = out_word;
endmodule

// File: rtl/hit_sel_chk.sv
module hit_sel_chk
    import hitsel_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   s1_valid,
    input logic [NSLOT*WORDW-1:0] slot_word,
    input logic [NSLOT-1:0]       slot_valid,
    input logic                   overflow
);
    p_reset_r8: assert property (@(posedge clk) rst |=> (slot_valid == '0 && !overflow));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !s1_valid) |=> (slot_valid == '0 && slot_word == '0 && !overflow));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!start && !s1_valid) |=> ($stable(slot_word) && $stable(slot_valid) && $stable(overflow)));

    p_ovf_full_r5: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (slot_valid == '1));

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        p_zero_r4: assert property (@(posedge clk) disable iff (rst)
            !slot_valid[i] |-> (slot_word[i*WORDW +: WORDW] == '0));
        if (i > 0) begin : g_pair
            p_pack_r4: assert property (@(posedge clk) disable iff (rst)
                slot_valid[i] |-> slot_valid[i-1]);
            p_order_r3: assert property (@(posedge clk) disable iff (rst)
                slot_valid[i] |-> (slot_word[i*WORDW + WORDW - 1 -: SAW] >
                                   slot_word[(i-1)*WORDW + WORDW - 1 -: SAW]));
        end
    end
endmodule

bind hit_sel_top hit_sel_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .s1_valid   (s1_valid),
    .slot_word  (slot_word),
    .slot_valid (slot_valid),
    .overflow   (overflow)
);

// File: tb/hit_sel_top_tb_top.sv
module hit_sel_top_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [4095:0] hit_map;
    logic [103:0] slot_word;
    logic [7:0]   slot_valid;
    logic         overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [12:0] exp_word [8];
    logic [7:0]  exp_valid;
    logic        exp_ovf;

    always #10 clk = ~clk;

    hit_sel_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hit_map    (hit_map),
        .slot_word  (slot_word),
        .slot_valid (slot_valid),
        .overflow   (overflow)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [4095:0] m);
        int n;
        n = 0;
        exp_valid = '0;
        for (int k = 0; k < 8; k++) exp_word[k] = '0;
        for (int s = 0; s < 128; s++) begin
            logic [31:0] px;
            int c;
            px = m[s*32 +: 32];
            if (px != 0) begin
                c = 0;
                while (!px[c]) c++;
                if (n < 8) begin
                    exp_word[n]  = {7'(s), 5'(c), ($countones(px) > 1)};
                    exp_valid[n] = 1'b1;
                end
                n++;
            end
        end
        exp_ovf = (n > 8);
    endtask

    task automatic run_case(input logic [4095:0] m, input string req);
        model(m);
        @(negedge clk);
        hit_map = m;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        check("R7 cleared", {slot_valid, overflow, slot_word}, '0);
        @(negedge clk);
        check("R6 valid", slot_valid, exp_valid);
        check("R5 overflow", overflow, exp_ovf);
        for (int k = 0; k < 8; k++) check(req, slot_word[k*13 +: 13], exp_word[k]);
        hit_map = ~m;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold", {slot_valid, overflow, slot_word},
              {exp_valid, exp_ovf, exp_word[7], exp_word[6], exp_word[5], exp_word[4],
               exp_word[3], exp_word[2], exp_word[1], exp_word[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4095:0] m;
        void'($urandom(32'h5EED_0C8A));
        rst = 1'b1;
        start = 1'b0;
        hit_map = '0;
        repeat (3) @(negedge clk);
        check("R8 reset", {slot_valid, overflow, slot_word}, '0);
        rst = 1'b0;

        run_case('0, "R4 empty");

        m = '0; m[127*32 + 31] = 1'b1;
        run_case(m, "R2 last strip");

        m = '0; m[5*32 + 3] = 1'b1; m[5*32 + 17] = 1'b1; m[40*32 + 9] = 1'b1;
        m[85*32 + 30] = 1'b1; m[85*32 + 0] = 1'b1;
        run_case(m, "R1 multi");

        m = '0;
        for (int s = 120; s < 128; s++) m[s*32 + (s % 32)] = 1'b1;
        run_case(m, "R3 last eight");

        m = '0;
        for (int s = 0; s < 9; s++) m[(s*14)*32 + s] = 1'b1;
        run_case(m, "R5 nine");

        m = '0;
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < 3; k++) m[(g*32 + k*7 + 3)*32 + g + k] = 1'b1;
        run_case(m, "R5 merge overflow");

        run_case('1, "R5 all");

        for (int it = 0; it < 40; it++) begin
            int nh;
            m = '0;
            nh = $urandom_range(0, 14);
            for (int k = 0; k < nh; k++) begin
                int s;
                s = $urandom_range(0, 127);
                m[s*32 + $urandom_range(0, 31)] = 1'b1;
                if ($urandom_range(0, 2) == 0) m[s*32 + $urandom_range(0, 31)] = 1'b1;
            end
            run_case(m, "R3 random");
        end

        m = '0; m[7*32 + 2] = 1'b1;
        model(m);
        @(negedge clk);
        hit_map = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 mid reset", {slot_valid, overflow, slot_word}, '0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule